// File: doc/BRIEF.md
# Rendering-Gated Dot Position Decoder

This block is the timing core of a raster video unit. It advances a horizontal dot counter and a vertical line counter by one on each clock, with one clock per dot. It also keeps a frame-parity bit. A host writes a pair of enable bits, one for background and one for sprites, through a single-cycle write strobe. Their OR is the rendering enable.

The write does not reach the position comparators on the dot it is made. It travels through a fixed arrival pipeline and takes effect three dots later. Each per-dot decision therefore depends on exactly when the write lands relative to the counter. The decoded strobes are:

- the start of sprite evaluation;
- the last fetch dot of a line;
- the sprite fetch window;
- the boundary where the tile shifters reload;
- the master render gate for the visible area;
- an odd-frame skip that shortens the pre-render line by one dot.

The downstream pixel and fetch logic consumes these strobes directly.

Top module: `dot_timing_gate`

## Requirements
- R1: The horizontal position counts 0 to 340 and then returns to 0 while the line number increments. The line number counts 0 to LINES-1 (default 262) and then returns to 0.
- R2: The enables are latched only on a cycle with `wr_en` high. The rendering enable is `wr_bg OR wr_spr`. A write sampled while `h_pos` shows dot N appears on `rend_active` while `h_pos` shows dot N+3, and not earlier. Without a write, the rendering enable holds.
- R3: `evl_start` is high exactly when the horizontal position is 65 and rendering is enabled.
- R4: `line_end` is high exactly when the horizontal position is 339 and rendering is enabled.
- R5: `fetch_win` is high exactly while the horizontal position is between 320 and 335 inclusive and rendering is enabled.
- R6: `reload_edge` is high exactly when the horizontal position modulo 8 is 0 or 1 and rendering is enabled.
- R7: `render_gate` is high exactly when the line is below 240 (VIS_H), the dot is below 256, and rendering is enabled.
- R8: The skip applies on the last line (LINES-1) of a frame whose parity bit is 1, at dot 339, when rendering is enabled. In that case `skip_dot` is high and the next dot is dot 0 of line 0. Dot 340 is not produced. Without rendering enabled, the line is full length.
- R9: `odd_frame` toggles on every wrap from the last line to line 0 and is otherwise stable.
- R10: A synchronous active-high `rst` clears both counters, the parity bit, the latched enables and the whole arrival pipeline.
- R11: A write made three dots before a comparator dot is seen at that dot. A write made two dots before it misses that dot and lands on the later side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock, one dot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for the enable pair |
| wr_bg | input | 1 | Background enable value written |
| wr_spr | input | 1 | Sprite enable value written |
| h_pos | output | HW (9) | Current dot within the line |
| v_pos | output | VW (9) | Current line within the frame |
| odd_frame | output | 1 | Frame parity bit |
| rend_active | output | 1 | Rendering enable as seen at the comparators |
| evl_start | output | 1 | Sprite evaluation start strobe |
| line_end | output | 1 | Dot-339 strobe |
| fetch_win | output | 1 | Sprite fetch window |
| reload_edge | output | 1 | Tile shifter reload boundary |
| render_gate | output | 1 | Master render gate for the visible area |
| skip_dot | output | 1 | Odd-frame skip strobe on the pre-render line |

## Verification
The bound checker checks several rules on every cycle:

- the counter bounds and single-step advance;
- the wrap after dot 340 and after a skip;
- the parity toggle and hold;
- the rule that the rendering enable only changes three cycles after a write strobe;
- the strobe conditions for `line_end`, `fetch_win` and `render_gate`.

Only the bench's scenarios can show the arrival-phase outcomes, that is, whether a write three dots before a boundary hits it and a write two dots before misses it. The same holds for whether a skip happens on an odd frame with rendering on versus off. The bench runs a behavioural reference model against every output on every clock, across directed writes and several frames of random writes.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    // Host-written enable pair.
    typedef struct packed {
        logic bg;
        logic spr;
    } en_pair_t;

    // Per-dot decisions produced by the decoder.
    typedef struct packed {
        logic evl_start;
        logic line_end;
        logic fetch_win;
        logic reload_edge;
        logic render_gate;
        logic skip_dot;
    } strobe_t;

endpackage

// File: rtl/dtg_counters.sv
module dtg_counters #(
    parameter int DOTS  = 341,
    parameter int LINES = 262,
    parameter int HW    = $clog2(DOTS),
    parameter int VW    = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          skip_i,
    output logic [HW-1:0] h_o,
    output logic [VW-1:0] v_o,
    output logic          odd_o
);

    localparam logic [HW-1:0] H_LAST = HW'(DOTS - 1);
    localparam logic [VW-1:0] V_LAST = VW'(LINES - 1);

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
        logic          odd;
    } cnt_t;

    cnt_t st_d, st_q;
    logic line_done;

    always_comb begin
        st_d      = st_q;
        line_done = skip_i || (st_q.h == H_LAST);
        if (line_done) begin
            st_d.h = '0;
            if (st_q.v == V_LAST) begin
                st_d.v   = '0;
                st_d.odd = ~st_q.odd;
            end else begin
                st_d.v = st_q.v + 1'b1;
            end
        end else begin
            st_d.h = st_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign h_o   = st_q.h;
    assign v_o   = st_q.v;
    assign odd_o = st_q.odd;

endmodule

// File: rtl/dtg_arrival.sv
module dtg_arrival
    import dtg_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_i,
    input  en_pair_t en_i,
    output en_pair_t late_o
);

    // Stage 0 is the host-side latch; each further stage is one dot of flight.
    typedef struct packed {
        en_pair_t [DEPTH-1:0] stg;
    } pipe_t;

    pipe_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (wr_i) p_d.stg[0] = en_i;
        for (int i = 1; i < DEPTH; i++) begin
            p_d.stg[i] = p_q.stg[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) p_q <= '0;
        else     p_q <= p_d;
    end

    assign late_o = p_q.stg[DEPTH-1];

endmodule

// File: rtl/dtg_decode.sv
module dtg_decode
    import dtg_pkg::*;
#(
    parameter int DOTS     = 341,
    parameter int LINES    = 262,
    parameter int VIS_W    = 256,
    parameter int VIS_H    = 240,
    parameter int EVAL_DOT = 65,
    parameter int END_DOT  = 339,
    parameter int FETCH_LO = 320,
    parameter int FETCH_HI = 335,
    parameter int TILE     = 8,
    parameter int HW       = $clog2(DOTS),
    parameter int VW       = $clog2(LINES)
) (
    input  logic [HW-1:0] h_i,
    input  logic [VW-1:0] v_i,
    input  logic          odd_i,
    input  logic          rend_i,
    output strobe_t       st_o
);

    localparam int TB = $clog2(TILE);
    localparam logic [HW-1:0] H_EVAL = HW'(EVAL_DOT);
    localparam logic [HW-1:0] H_END  = HW'(END_DOT);
    localparam logic [HW-1:0] H_FLO  = HW'(FETCH_LO);
    localparam logic [HW-1:0] H_FHI  = HW'(FETCH_HI);
    localparam logic [HW-1:0] H_VISW = HW'(VIS_W);
    localparam logic [VW-1:0] V_VISH = VW'(VIS_H);
    localparam logic [VW-1:0] V_PRE  = VW'(LINES - 1);

    logic in_visible;
    logic reload_phase;

    // Position within a tile: power-of-two tiles take the low bits.
    generate
        if (TB > 0) begin : g_tile
            assign reload_phase = (h_i[TB-1:0] <= TB'(1));
        end else begin : g_notile
            assign reload_phase = 1'b1;
        end
    endgenerate

    always_comb begin
        in_visible         = (v_i < V_VISH) && (h_i < H_VISW);
        st_o.evl_start     = rend_i && (h_i == H_EVAL);
        st_o.line_end      = rend_i && (h_i == H_END);
        st_o.fetch_win     = rend_i && (h_i >= H_FLO) && (h_i <= H_FHI);
        st_o.reload_edge   = rend_i && reload_phase;
        st_o.render_gate   = rend_i && in_visible;
        st_o.skip_dot      = rend_i && odd_i && (v_i == V_PRE) && (h_i == H_END);
    end

endmodule

// File: rtl/dot_timing_gate.sv
module dot_timing_gate
    import dtg_pkg::*;
#(
    parameter int DOTS_PER_LINE = 341,
    parameter int LINES         = 262,
    parameter int VIS_W         = 256,
    parameter int VIS_H         = 240,
    parameter int EVAL_DOT      = 65,
    parameter int END_DOT       = 339,
    parameter int FETCH_LO      = 320,
    parameter int FETCH_HI      = 335,
    parameter int TILE          = 8,
    parameter int ARRIVAL       = 3,
    localparam int HW           = $clog2(DOTS_PER_LINE),
    localparam int VW           = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_bg,
    input  logic          wr_spr,
    output logic [HW-1:0] h_pos,
    output logic [VW-1:0] v_pos,
    output logic          odd_frame,
    output logic          rend_active,
    output logic          evl_start,
    output logic          line_end,
    output logic          fetch_win,
    output logic          reload_edge,
    output logic          render_gate,
    output logic          skip_dot
);

    en_pair_t wr_pair, late_pair;
    strobe_t  strb;

    assign wr_pair.bg  = wr_bg;
    assign wr_pair.spr = wr_spr;

    dtg_counters #(
        .DOTS (DOTS_PER_LINE),
        .LINES(LINES),
        .HW   (HW),
        .VW   (VW)
    ) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .skip_i(strb.skip_dot),
        .h_o   (h_pos),
        .v_o   (v_pos),
        .odd_o (odd_frame)
    );

    dtg_arrival #(
        .DEPTH(ARRIVAL)
    ) u_arr (
        .clk   (clk),
        .rst   (rst),
        .wr_i  (wr_en),
        .en_i  (wr_pair),
        .late_o(late_pair)
    );

    assign rend_active = late_pair.bg | late_pair.spr;

    dtg_decode #(
        .DOTS    (DOTS_PER_LINE),
        .LINES   (LINES),
        .VIS_W   (VIS_W),
        .VIS_H   (VIS_H),
        .EVAL_DOT(EVAL_DOT),
        .END_DOT (END_DOT),
        .FETCH_LO(FETCH_LO),
        .FETCH_HI(FETCH_HI),
        .TILE    (TILE),
        .HW      (HW),
        .VW      (VW)
    ) u_dec (
        .h_i   (h_pos),
        .v_i   (v_pos),
        .odd_i (odd_frame),
        .rend_i(rend_active),
        .st_o  (strb)
    );

    assign evl_start   = strb.evl_start;
    assign line_end    = strb.line_end;
    assign fetch_win   = strb.fetch_win;
    assign reload_edge = strb.reload_edge;
    assign render_gate = strb.render_gate;
    assign skip_dot    = strb.skip_dot;

endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
    parameter int DOTS     = 341,
    parameter int LINES    = 262,
    parameter int VIS_W    = 256,
    parameter int VIS_H    = 240,
    parameter int END_DOT  = 339,
    parameter int FETCH_LO = 320,
    parameter int FETCH_HI = 335,
    parameter int ARRIVAL  = 3,
    parameter int HW       = $clog2(DOTS),
    parameter int VW       = $clog2(LINES)
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [HW-1:0] h_pos,
    input logic [VW-1:0] v_pos,
    input logic          odd_frame,
    input logic          rend_active,
    input logic          line_end,
    input logic          fetch_win,
    input logic          render_gate,
    input logic          skip_dot
);

    localparam logic [HW-1:0] H_LAST = HW'(DOTS - 1);
    localparam logic [VW-1:0] V_LAST = VW'(LINES - 1);

    logic past_ok   = 1'b0;
    logic rst_seen  = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
        if (rst) rst_seen <= 1'b1;
    end

    a_r1_h_bound: assert property (@(posedge clk) disable iff (rst || !past_ok)
        h_pos <= H_LAST);

    a_r1_h_step: assert property (@(posedge clk) disable iff (rst || !past_ok)
        ($past(h_pos) != H_LAST && !$past(skip_dot)) |-> (h_pos == $past(h_pos) + 1'b1));

    a_r1_wrap: assert property (@(posedge clk) disable iff (rst || !past_ok)
        ($past(h_pos) == H_LAST) |-> (h_pos == '0));

    a_r2_arrival: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (rend_active != $past(rend_active)) |-> $past(wr_en, ARRIVAL));

    a_r4_line_end: assert property (@(posedge clk) disable iff (rst || !past_ok)
        line_end |-> (rend_active && h_pos == HW'(END_DOT)));

    a_r5_fetch: assert property (@(posedge clk) disable iff (rst || !past_ok)
        fetch_win |-> (rend_active && h_pos >= HW'(FETCH_LO) && h_pos <= HW'(FETCH_HI)));

    a_r7_gate: assert property (@(posedge clk) disable iff (rst || !past_ok)
        render_gate |-> (rend_active && h_pos < HW'(VIS_W) && v_pos < VW'(VIS_H)));

    a_r8_skip_wrap: assert property (@(posedge clk) disable iff (rst || !past_ok)
        skip_dot |=> (h_pos == '0 && v_pos == '0));

    a_r9_toggle: assert property (@(posedge clk) disable iff (rst || !past_ok)
        ($past(v_pos) == V_LAST && v_pos == '0) |-> (odd_frame != $past(odd_frame)));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (v_pos != '0 || $past(v_pos) == '0) |-> $stable(odd_frame));

    a_r10_reset: assert property (@(posedge clk)
        (rst_seen && $past(rst)) |-> (h_pos == '0 && v_pos == '0 && !odd_frame && !rend_active));

endmodule

bind dot_timing_gate dtg_checker #(
    .DOTS    (DOTS_PER_LINE),
    .LINES   (LINES),
    .VIS_W   (VIS_W),
    .VIS_H   (VIS_H),
    .END_DOT (END_DOT),
    .FETCH_LO(FETCH_LO),
    .FETCH_HI(FETCH_HI),
    .ARRIVAL (ARRIVAL),
    .HW      (HW),
    .VW      (VW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .h_pos      (h_pos),
    .v_pos      (v_pos),
    .odd_frame  (odd_frame),
    .rend_active(rend_active),
    .line_end   (line_end),
    .fetch_win  (fetch_win),
    .render_gate(render_gate),
    .skip_dot   (skip_dot)
);

// File: tb/sim_dot_timing_gate.sv
`timescale 1ns/1ps
module sim_dot_timing_gate;

    localparam int LN  = 12;   // shortened frame keeps the run small
    localparam int VH  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0, wr_bg = 1'b0, wr_spr = 1'b0;
    logic [8:0] h_pos;
    logic [3:0] v_pos;
    logic odd_frame, rend_active, evl_start, line_end, fetch_win;
    logic reload_edge, render_gate, skip_dot;

    int vectors = 0;
    int miscompares = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dot_timing_gate #(.LINES(LN), .VIS_H(VH)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bg(wr_bg), .wr_spr(wr_spr),
        .h_pos(h_pos), .v_pos(v_pos), .odd_frame(odd_frame),
        .rend_active(rend_active), .evl_start(evl_start), .line_end(line_end),
        .fetch_win(fetch_win), .reload_edge(reload_edge),
        .render_gate(render_gate), .skip_dot(skip_dot)
    );

    // Behavioural reference model
    int mh = 0, mv = 0, modd = 0, mlatch = 0;
    bit arrq[$] = '{1'b0, 1'b0, 1'b0};

    always @(posedge clk) begin
        if (rst) begin
            mh = 0; mv = 0; modd = 0; mlatch = 0;
            arrq = '{1'b0, 1'b0, 1'b0};
        end else begin
            bit r, sk;
            r  = arrq[0];
            sk = r && (modd == 1) && (mv == LN-1) && (mh == 339);
            if (mh == 340 || sk) begin
                mh = 0;
                if (mv == LN-1) begin mv = 0; modd = 1 - modd; end
                else mv = mv + 1;
            end else mh = mh + 1;
            if (wr_en) mlatch = (wr_bg | wr_spr) ? 1 : 0;
            arrq.push_back(mlatch != 0);
            void'(arrq.pop_front());
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0d expected=%0d (h=%0d v=%0d)", req, what, act, exp, mh, mv);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            bit r;
            r = arrq[0];
            chk("R1", "h_pos", h_pos, mh);
            chk("R1", "v_pos", v_pos, mv);
            chk("R9", "odd_frame", odd_frame, modd);
            chk("R2", "rend_active", rend_active, r);
            chk("R3", "evl_start", evl_start, r && mh == 65);
            chk("R4", "line_end", line_end, r && mh == 339);
            chk("R5", "fetch_win", fetch_win, r && mh >= 320 && mh <= 335);
            chk("R6", "reload_edge", reload_edge, r && (mh % 8) <= 1);
            chk("R7", "render_gate", render_gate, r && mh < 256 && mv < VH);
            chk("R8", "skip_dot", skip_dot, r && modd == 1 && mv == LN-1 && mh == 339);
        end
    end

    task automatic wait_h(int h);
        do @(negedge clk); while (h_pos != h);
    endtask

    task automatic wait_vh(int v, int h, int odd);
        do @(negedge clk); while (!(h_pos == h && v_pos == v && odd_frame == odd));
    endtask

    task automatic write(bit bg, bit spr);
        wr_en = 1'b1; wr_bg = bg; wr_spr = spr;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state
        chk("R10", "h_pos", h_pos, 0);
        chk("R10", "v_pos", v_pos, 0);
        chk("R10", "odd_frame", odd_frame, 0);
        chk("R10", "rend_active", rend_active, 0);
        rst = 1'b0;
        cmp_on = 1'b1;

        // R11: three dots ahead of dot 65 lands on it
        wait_h(62); write(1, 0);
        wait_h(65); chk("R11", "evl_start write at 62", evl_start, 1);
        wait_h(100); write(0, 0);
        // R11: two dots ahead misses dot 65
        wait_h(63); write(0, 1);
        wait_h(65); chk("R11", "evl_start write at 63", evl_start, 0);
        @(negedge clk); chk("R2", "sprite-only rendering", rend_active, 1);
        wait_h(200); write(0, 0);
        // R11 at the dot-339 boundary
        wait_h(336); write(1, 1);
        wait_h(339); chk("R11", "line_end write at 336", line_end, 1);
        wait_h(20); write(0, 0);
        wait_h(337); write(1, 0);
        wait_h(339); chk("R11", "line_end write at 337", line_end, 0);
        @(negedge clk); chk("R2", "rend at 340", rend_active, 1);
        // R5, R6, R7 edges with rendering on
        wait_h(320); chk("R5", "fetch at 320", fetch_win, 1);
        wait_h(336); chk("R5", "fetch at 336", fetch_win, 0);
        wait_h(8);   chk("R6", "reload at 8", reload_edge, 1);
        wait_h(10);  chk("R6", "reload at 10", reload_edge, 0);
        wait_h(255); chk("R7", "gate at 255", render_gate, (v_pos < VH) ? 1 : 0);
        @(negedge clk); chk("R7", "gate at 256", render_gate, 0);

        // R9: even-frame wrap is full length and toggles parity
        wait_vh(LN-1, 340, 0);
        @(negedge clk);
        chk("R9", "parity after wrap", odd_frame, 1);
        chk("R1", "wrap to line 0", v_pos, 0);
        // R8: odd frame with rendering skips dot 340
        wait_vh(LN-1, 339, 1);
        chk("R8", "skip_dot", skip_dot, 1);
        @(negedge clk);
        chk("R8", "h after skip", h_pos, 0);
        chk("R8", "v after skip", v_pos, 0);
        chk("R9", "parity after odd wrap", odd_frame, 0);

        // Random writes over several frames
        for (int i = 0; i < 400; i++) begin
            repeat (1 + ($urandom % 40)) @(negedge clk);
            write(1'($urandom), 1'($urandom));
        end

        // R8: odd frame with rendering off keeps dot 340
        write(0, 0);
        wait_vh(LN-1, 339, 1);
        chk("R8", "no skip when off", skip_dot, 0);
        @(negedge clk);
        chk("R8", "dot 340 present", h_pos, 340);
        repeat (5) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            #(150000 * 5);
        join_any
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=finished");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule